// File: doc/BRIEF.md
# Flash Erase and Program Command Sequencer

This block sits on the host side of a byte-wide flash device and turns one request into the complete bus conversation the device expects. A request carries an operation code, a target address and, for a program, a data byte. The sequencer writes the two-cycle command for that operation, then reads the device status byte until its ready bit rises, ranks any error bits into a single result code, and tidies the device (clear status, back to array mode) when that code is not zero. It reports with a single-cycle `done` pulse carrying the result.

While an erase or a program is in progress, a separate suspend request can stop it so that one array byte can be read at another address. The sequencer issues the suspend command, waits for ready, switches the device to array mode, reads the byte and returns it together with a flag that says whether the operation was actually suspended. If it was, the sequencer resumes it and keeps polling. If the operation had already finished, the saved status is ranked as the final result. Every bus access takes one clock cycle, and read data is sampled in the same cycle the read strobe is high.

States: `S_IDLE`, `S_SETUP` (first command byte), `S_CONFIRM` (confirm byte or program data), `S_POLL` (status read), `S_SUS_WR` (suspend command), `S_SUS_POLL` (status read after suspend), `S_SUS_ARR` (array-mode command), `S_SUS_RD` (array read), `S_RESUME` (resume command), `S_CLEAR` (clear-status command), `S_ARRAY` (array-mode command), `S_DONE`. The transitions are: idle to setup on an accepted request; setup to confirm to poll; poll to done on ready with zero result, to clear on ready with an error or on timeout, to suspend-write when a suspend is pending and the device is busy; suspend-write to suspend-poll; suspend-poll to array-command on ready, to clear on timeout; array-command to array-read; array-read to resume when suspended, otherwise to clear or done by the saved status; resume to poll; clear to array to done; done to idle.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high only in the idle state; a request is taken when `req_valid` is high while idle and `req_op` is 0 (erase), 1 (program) or 2 (clear all block locks); `req_op` 3, and any request made while busy, causes no bus write.
- R2: An erase writes 20H then D0H to `req_addr`, then reads status at that address, one read per cycle, until bit 7 of the read byte is 1.
- R3: A program writes 40H then `req_data` to `req_addr`, then polls status as in R2.
- R4: A clear-locks request writes 60H then D0H, then polls status as in R2.
- R5: The final status is ranked in this priority: bit 3 set gives result 1; else bit 1 set gives 2; else bits 4 and 5 both set give 3; else the operation's failure bit gives 4; else 0.
- R6: The failure bit of R5 is bit 4 for a program and bit 5 for an erase or clear-locks; the other of the two bits alone has no effect on the result.
- R7: When the result is not 0 the sequencer writes 50H then FFH before `done`; a zero result produces no further bus write after the last status read.
- R8: If `POLL_LIMIT` consecutive status reads (default 64) all show bit 7 low, the result is 5 and the R7 tail follows; a ready on the last allowed read still completes normally.
- R9: `done` is high for exactly one cycle per accepted request and `result` is valid while it is high.
- R10: A suspend request (`susp_req` high while the sequencer is polling an erase or program) is served at the next status read that shows busy: the sequencer writes B0H, polls to ready, writes FFH, reads `susp_addr`, and pulses `susp_done` for one cycle with the byte on `susp_data`.
- R11: Whether the operation was suspended is taken from status bit 6 for an erase and bit 2 for a program and shown on `susp_hit`; when suspended the sequencer writes D0H in the cycle `susp_done` is high and goes back to polling; otherwise the status saved at the suspend poll is ranked by R5 as the final result.
- R12: A pending suspend is dropped, with no B0H write and no `susp_done`, when the operation's own polling completes first; a suspend request during a clear-locks operation is ignored.
- R13: During and right after reset, `req_ready` is 1 and `done`, `susp_done`, `bus_we`, `bus_re` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 erase, 1 program, 2 clear locks, 3 ignored |
| req_addr | input | AW | Target byte or block address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| susp_req | input | 1 | Suspend request, held until `susp_done` or `done` |
| susp_addr | input | AW | Address to read while suspended |
| susp_done | output | 1 | One-cycle pulse: suspend read complete |
| susp_hit | output | 1 | 1 if the operation was really suspended |
| susp_data | output | 8 | Byte read while suspended |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 low voltage, 2 protected, 3 bad sequence, 4 operation failed, 5 timeout |
| bus_we | output | 1 | Device write strobe, one cycle per write |
| bus_re | output | 1 | Device read strobe, one cycle per read |
| bus_addr | output | AW | Device address |
| bus_wdata | output | 8 | Device write byte |
| bus_rdata | input | 8 | Device read byte, valid in the cycle `bus_re` is high |

## Verification
The assertions assume that the device answers every read within the same cycle, so that a status byte sampled at the edge belongs to the read strobe of that cycle, and that `susp_req` stays high until `susp_done` or `done` is seen and then drops. They also assume that `req_op` is stable in the cycle `req_valid` is high. The bench keeps within this by modelling the device with a combinational read path over registered state, driving every input on the falling edge and releasing `susp_req` on the falling edge at which it first sees either pulse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE   = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_UNLOCK  = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_CONFIRM,
        S_POLL,
        S_SUS_WR,
        S_SUS_POLL,
        S_SUS_ARR,
        S_SUS_RD,
        S_RESUME,
        S_CLEAR,
        S_ARRAY,
        S_DONE
    } state_e;

    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_UNLOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
    localparam logic [7:0] CMD_CLR_STATUS   = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;

    localparam int SB_READY   = 7;
    localparam int SB_ESUSP   = 6;
    localparam int SB_EFAIL   = 5;
    localparam int SB_PFAIL   = 4;
    localparam int SB_VLOW    = 3;
    localparam int SB_PSUSP   = 2;
    localparam int SB_PROTECT = 1;

    localparam logic [2:0] RES_OK      = 3'd0;
    localparam logic [2:0] RES_VOLT    = 3'd1;
    localparam logic [2:0] RES_PROTECT = 3'd2;
    localparam logic [2:0] RES_SEQ     = 3'd3;
    localparam logic [2:0] RES_FAIL    = 3'd4;
    localparam logic [2:0] RES_TIMEOUT = 3'd5;

endpackage

// File: rtl/flash_seq_status_decode.sv
module flash_seq_status_decode
    import flash_seq_pkg::*;
(
    input  logic [7:1] stat,
    input  op_e        op,
    output logic       ready,
    output logic       hit,
    output logic [2:0] code
);

    logic op_fail;

    always_comb begin
        ready   = stat[SB_READY];
        hit     = (op == OP_PROGRAM) ? stat[SB_PSUSP] : stat[SB_ESUSP];
        op_fail = (op == OP_PROGRAM) ? stat[SB_PFAIL] : stat[SB_EFAIL];
        if (stat[SB_VLOW]) begin
            code = RES_VOLT;
        end else if (stat[SB_PROTECT]) begin
            code = RES_PROTECT;
        end else if (stat[SB_PFAIL] && stat[SB_EFAIL]) begin
            code = RES_SEQ;
        end else if (op_fail) begin
            code = RES_FAIL;
        end else begin
            code = RES_OK;
        end
    end

endmodule

// File: rtl/flash_seq_poll_timer.sv
module flash_seq_poll_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 21,
    parameter int POLL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          req_ready,
    input  logic          susp_req,
    input  logic [AW-1:0] susp_addr,
    output logic          susp_done,
    output logic          susp_hit,
    output logic [7:0]    susp_data,
    output logic          done,
    output logic [2:0]    result,
    output logic          bus_we,
    output logic          bus_re,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata
);

    state_e        state, nxt;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] saddr_q;
    logic [7:0]    data_q;
    logic          pend_q;
    logic [7:1]    saved_q;
    logic [2:0]    res_q;
    logic          sdone_q;
    logic          shit_q;
    logic [7:0]    sdata_q;

    logic [7:1]    dec_in;
    logic          st_ready;
    logic          st_hit;
    logic [2:0]    st_code;
    logic          polling;
    logic          t_last;
    logic          take_req;

    assign take_req = req_valid && (op_e'(req_op) != OP_NONE);
    assign polling  = (state == S_POLL) || (state == S_SUS_POLL);
    assign dec_in   = (state == S_SUS_RD) ? saved_q : bus_rdata[7:1];

    flash_seq_status_decode u_decode (
        .stat  (dec_in),
        .op    (op_q),
        .ready (st_ready),
        .hit   (st_hit),
        .code  (st_code)
    );

    flash_seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!polling),
        .inc   (polling && !st_ready),
        .last  (t_last)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (take_req) nxt = S_SETUP;
            S_SETUP:    nxt = S_CONFIRM;
            S_CONFIRM:  nxt = S_POLL;
            S_POLL: begin
                if (st_ready)    nxt = (st_code != RES_OK) ? S_CLEAR : S_DONE;
                else if (t_last) nxt = S_CLEAR;
                else if (pend_q) nxt = S_SUS_WR;
            end
            S_SUS_WR:   nxt = S_SUS_POLL;
            S_SUS_POLL: begin
                if (st_ready)    nxt = S_SUS_ARR;
                else if (t_last) nxt = S_CLEAR;
            end
            S_SUS_ARR:  nxt = S_SUS_RD;
            S_SUS_RD: begin
                if (st_hit)                nxt = S_RESUME;
                else if (st_code != RES_OK) nxt = S_CLEAR;
                else                        nxt = S_DONE;
            end
            S_RESUME:   nxt = S_POLL;
            S_CLEAR:    nxt = S_ARRAY;
            S_ARRAY:    nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // request, suspend and result bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_ERASE;
            addr_q  <= '0;
            saddr_q <= '0;
            data_q  <= '0;
            pend_q  <= 1'b0;
            saved_q <= '0;
            res_q   <= RES_OK;
            sdone_q <= 1'b0;
            shit_q  <= 1'b0;
            sdata_q <= '0;
        end else begin
            sdone_q <= 1'b0;
            if (state == S_IDLE && take_req) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (state == S_IDLE || state == S_SUS_WR) begin
                pend_q <= 1'b0;
            end else if (state == S_POLL && susp_req && !pend_q && op_q != OP_UNLOCK) begin
                pend_q  <= 1'b1;
                saddr_q <= susp_addr;
            end
            if (state == S_POLL || state == S_SUS_POLL) begin
                if (st_ready)    res_q <= st_code;
                else if (t_last) res_q <= RES_TIMEOUT;
            end
            if (state == S_SUS_POLL && st_ready) begin
                saved_q <= bus_rdata[7:1];
            end
            if (state == S_SUS_RD) begin
                sdone_q <= 1'b1;
                shit_q  <= st_hit;
                sdata_q <= bus_rdata;
                res_q   <= st_code;
            end
        end
    end

    // outputs
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = addr_q;
        bus_wdata = 8'h00;
        unique case (state)
            S_SETUP: begin
                bus_we = 1'b1;
                unique case (op_q)
                    OP_PROGRAM: bus_wdata = CMD_PROG_SETUP;
                    OP_UNLOCK:  bus_wdata = CMD_UNLOCK_SETUP;
                    default:    bus_wdata = CMD_ERASE_SETUP;
                endcase
            end
            S_CONFIRM: begin
                bus_we    = 1'b1;
                bus_wdata = (op_q == OP_PROGRAM) ? data_q : CMD_CONFIRM;
            end
            S_POLL, S_SUS_POLL: bus_re = 1'b1;
            S_SUS_WR: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_SUSPEND;
            end
            S_SUS_ARR, S_ARRAY: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_READ_ARRAY;
            end
            S_SUS_RD: begin
                bus_re   = 1'b1;
                bus_addr = saddr_q;
            end
            S_RESUME: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_CONFIRM;
            end
            S_CLEAR: begin
                bus_we    = 1'b1;
                bus_wdata = CMD_CLR_STATUS;
            end
            default: begin
                bus_we = 1'b0;
            end
        endcase
        req_ready = (state == S_IDLE);
        done      = (state == S_DONE);
        result    = res_q;
        susp_done = sdone_q;
        susp_hit  = shit_q;
        susp_data = sdata_q;
    end

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ready,
    input logic       done,
    input logic [2:0] result,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] bus_wdata,
    input logic       susp_done,
    input logic       susp_hit
);

    // R9: completion strobe lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an accepted request starts with a setup write in the next cycle
    a_r1_accept_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_op != 2'd3) |=>
        (bus_we && !req_ready &&
         (bus_wdata == 8'h20 || bus_wdata == 8'h40 || bus_wdata == 8'h60)));

    // R7: an error result is preceded by the array-mode write
    a_r7_error_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 3'd0) |-> ($past(bus_we) && $past(bus_wdata) == 8'hFF));

    // R10: the suspend report follows a device read
    a_r10_susp_read: assert property (@(posedge clk) disable iff (!rst_n)
        susp_done |-> $past(bus_re));

    // R11: a real suspension is resumed in the reporting cycle
    a_r11_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_done && susp_hit) |-> (bus_we && bus_wdata == 8'hD0));

endmodule

bind flash_seq flash_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .done      (done),
    .result    (result),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .susp_done (susp_done),
    .susp_hit  (susp_hit)
);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam int NV = 13;
    localparam int LOGN = 512;

    // {op, busy reads, final status, expected result}
    localparam logic [31:0] VEC [NV] = '{
        32'h00_02_80_00,  // R2 erase ok
        32'h00_03_88_01,  // R5 low voltage
        32'h00_01_BA_01,  // R5 voltage outranks all
        32'h01_02_82_02,  // R3 R5 protect
        32'h01_00_B2_02,  // R5 protect outranks sequence, ready at once
        32'h02_02_B0_03,  // R4 R5 sequence error
        32'h01_04_90_04,  // R6 program failure bit 4
        32'h00_02_A0_04,  // R6 erase failure bit 5
        32'h01_01_A0_00,  // R6 bit 5 alone ignored for program
        32'h02_01_A0_04,  // R6 clear-locks failure bit 5
        32'h00_02_90_00,  // R6 bit 4 alone ignored for erase
        32'h00_3F_80_00,  // R8 ready on last allowed read
        32'h00_40_80_05   // R8 timeout
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          req_ready;
    logic          susp_req = 1'b0;
    logic [AW-1:0] susp_addr = '0;
    logic          susp_done;
    logic          susp_hit;
    logic [7:0]    susp_data;
    logic          done;
    logic [2:0]    result;
    logic          bus_we;
    logic          bus_re;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;

    int checks = 0;
    int errors = 0;

    // device model configuration (bench-driven)
    int       m_cfg_busy = 0;
    logic [7:0] m_fin = 8'h80;
    logic     m_late = 1'b0;

    // device model state
    int       m_busy;
    logic     m_arr;
    logic     m_susp;
    logic     m_isprog;
    logic [7:0] m_prev;
    int       wcnt;
    logic [7:0] wlog [LOGN];

    // captured outcome
    logic       got_susp;
    logic       got_hit;
    logic [7:0] got_sdata;
    logic [2:0] got_res;
    logic       got_done;

    flash_seq #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready),
        .susp_req(susp_req), .susp_addr(susp_addr), .susp_done(susp_done),
        .susp_hit(susp_hit), .susp_data(susp_data),
        .done(done), .result(result),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        if (m_arr)        bus_rdata = bus_addr[7:0] ^ 8'h5A;
        else if (m_susp)  bus_rdata = m_isprog ? 8'h84 : 8'hC0;
        else if (m_busy > 0) bus_rdata = 8'h00;
        else              bus_rdata = m_fin;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_arr <= 1'b0; m_susp <= 1'b0;
            m_isprog <= 1'b0; m_prev <= 8'h00; wcnt <= 0;
        end else begin
            if (bus_re && !m_arr && !m_susp && m_busy > 0) m_busy <= m_busy - 1;
            if (bus_we) begin
                wlog[wcnt % LOGN] <= bus_wdata;
                wcnt   <= wcnt + 1;
                m_prev <= bus_wdata;
                if (m_prev == 8'h40) begin
                    m_busy <= m_cfg_busy; m_arr <= 1'b0; m_isprog <= 1'b1;
                end else begin
                    case (bus_wdata)
                        8'hFF: m_arr <= 1'b1;
                        8'hB0: begin
                            m_arr <= 1'b0;
                            if (!m_late && m_busy > 0) m_susp <= 1'b1;
                        end
                        8'hD0: begin
                            m_arr <= 1'b0;
                            if (m_susp) m_susp <= 1'b0;
                            else if (m_prev == 8'h20 || m_prev == 8'h60) begin
                                m_busy <= m_cfg_busy; m_isprog <= 1'b0;
                            end
                        end
                        default: m_arr <= 1'b0;
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        got_susp = 1'b0; got_done = 1'b0; got_hit = 1'b0; got_sdata = 8'h00; got_res = 3'd7;
        for (int n = 0; n < 3000 && !got_done; n++) begin
            @(negedge clk);
            if (susp_done) begin
                got_susp = 1'b1; got_hit = susp_hit; got_sdata = susp_data;
                susp_req = 1'b0;
            end
            if (done) begin
                got_done = 1'b1; got_res = result; susp_req = 1'b0;
            end
        end
        chk(got_done, "R9 watchdog done seen", got_done, 1);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
    endtask

    // kind: 0 no suspend, 1 suspended, 2 finished before suspend, 3 dropped
    task automatic exec(input logic [1:0] op, input int busy, input logic [7:0] fin,
                        input int kind, input logic [2:0] exp_res,
                        input logic [AW-1:0] addr, input logic [7:0] data, input string tag);
        logic [7:0] exp [8];
        int ne;
        int start;
        logic [AW-1:0] sa;
        sa = addr ^ 21'h0_0137;
        @(negedge clk);
        m_cfg_busy = busy; m_fin = fin; m_late = (kind == 2);
        start = wcnt;
        req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
        susp_addr = sa; susp_req = (kind != 0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk(got_res == exp_res, {tag, " result"}, got_res, exp_res);
        exp[0] = (op == 2'd1) ? 8'h40 : (op == 2'd2) ? 8'h60 : 8'h20;
        exp[1] = (op == 2'd1) ? data : 8'hD0;
        ne = 2;
        if (kind == 1) begin exp[2] = 8'hB0; exp[3] = 8'hFF; exp[4] = 8'hD0; ne = 5; end
        if (kind == 2) begin exp[2] = 8'hB0; exp[3] = 8'hFF; ne = 4; end
        if (exp_res != 3'd0) begin exp[ne] = 8'h50; exp[ne+1] = 8'hFF; ne = ne + 2; end
        chk(wcnt - start == ne, {tag, " write count"}, wcnt - start, ne);
        for (int k = 0; k < ne && k < wcnt - start; k++)
            chk(wlog[(start + k) % LOGN] == exp[k], {tag, " write byte"},
                wlog[(start + k) % LOGN], exp[k]);
        if (kind == 1 || kind == 2) begin
            chk(got_susp, {tag, " susp_done seen"}, got_susp, 1);
            chk(got_hit == (kind == 1), {tag, " susp_hit"}, got_hit, kind == 1);
            chk(got_sdata == (sa[7:0] ^ 8'h5A), {tag, " susp_data"}, got_sdata, sa[7:0] ^ 8'h5A);
        end else begin
            chk(!got_susp, {tag, " no susp_done"}, got_susp, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R13 reset state
        #(CLK_PERIOD * 2 + 1);
        chk(req_ready && !done && !susp_done && !bus_we && !bus_re, "R13 in reset",
            {req_ready, done, susp_done, bus_we, bus_re}, 5'b10000);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !susp_done && !bus_we && !bus_re, "R13 after reset",
            {req_ready, done, susp_done, bus_we, bus_re}, 5'b10000);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            exec(VEC[i][25:24], int'(VEC[i][23:16]), VEC[i][15:8], 0, VEC[i][2:0],
                 AW'(i * 32'h10000 + 32'h42), 8'hC3 ^ 8'(i), $sformatf("R5 vec%0d", i));
        end

        // R1 op 3 ignored
        begin
            int s0;
            s0 = wcnt;
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd3;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(wcnt == s0, "R1 op3 no write", wcnt - s0, 0);
            chk(req_ready, "R1 op3 still idle", req_ready, 1);
        end

        // R1 request while busy ignored
        begin
            int s0;
            s0 = wcnt;
            m_cfg_busy = 5; m_fin = 8'h80; m_late = 1'b0;
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd0; req_addr = 21'h1_0000;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(!req_ready, "R1 busy not ready", req_ready, 0);
            req_valid = 1'b1; req_op = 2'd1; req_data = 8'h11;
            @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            chk(wcnt - s0 == 2, "R1 busy request ignored", wcnt - s0, 2);
            chk(got_res == 3'd0, "R1 busy run result", got_res, 0);
        end

        // R10 R11 suspend an erase and resume
        exec(2'd0, 6, 8'h80, 1, 3'd0, 21'h0A_0000, 8'h00, "R10 erase suspend");
        // R11 suspend a program (bit 2), then failure after resume
        exec(2'd1, 6, 8'h90, 1, 3'd4, 21'h0B_0055, 8'h3C, "R11 program suspend");
        // R11 operation finished before suspend: saved status ranked
        exec(2'd0, 3, 8'hA0, 2, 3'd4, 21'h0C_0000, 8'h00, "R11 late suspend");
        // R12 pending suspend dropped when polling completes first
        exec(2'd0, 1, 8'h80, 3, 3'd0, 21'h0D_0000, 8'h00, "R12 dropped suspend");
        // R12 suspend ignored for clear-locks
        exec(2'd2, 5, 8'h80, 3, 3'd0, 21'h0E_0000, 8'h00, "R12 unlock no suspend");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule